// File: doc/BRIEF.md
# Serial Clock Synthesizer Programming Sequencer

This block writes a new frequency setting into an external clock-synthesizer chip. It drives three wires, a serial data bit, a serial clock and a strobe, which share one 8-bit control byte `ctrl_o`. A request carries a 5-bit location address, a 13-bit program word and a saved control byte. The sequencer clears the control byte and waits a settle interval. It then raises a display-disable flag and sends a two-step preamble, followed by a 21-bit serial frame. The frame is a fixed three-bit header, then the location address, then the program word. Each step is paced by a strobe, and each strobe is preceded by a programmable wait.

After the frame, the block waits a short tail interval. It then drops the display-disable flag and puts back the saved control byte with the strobe bit set. After a long final interval it drives the low four location bits, again with the strobe set, and pulses `done_o`. Every interval is set in microseconds and converted to clock cycles from the clock-frequency parameter.

The request port is valid/ready. `req_ready_o` is high only while the sequencer is idle. A request is taken in the cycle where `req_valid_i` and `req_ready_o` are both high. A request held while `req_ready_o` is low is not stored and has no effect. No stall applies to the outputs: the external chip is driven open-loop.

Top module: `clkgen_loader`

## Requirements
- R1: While `rst_n` is low, and after its release until a request is taken, `ctrl_o` is 0x00, `disp_off_o` and `busy_o` and `done_o` are 0, and `req_ready_o` is 1.
- R2: A request is taken when `req_valid_i` and `req_ready_o` are both high. `busy_o` is high from the cycle after acceptance until the cycle `done_o` pulses. `req_ready_o` is low whenever `busy_o` is high. Requests presented while busy are ignored: the frame sent is that of the accepted request.
- R3: In the cycle after acceptance `ctrl_o` is 0x00 and `disp_off_o` is still 0. `disp_off_o` rises after the settle wait and stays high for every strobe of the preamble and the frame.
- R4: Bit positions of `ctrl_o`: bit 0 is select, bit 2 is serial data, bit 3 is serial clock, bit 6 is strobe. The preamble is two strobes. The first strobe has the other bits at 0x00, giving 0x40 while the strobe is high. The second has them at 0x01, giving 0x41.
- R5: Each frame bit takes two strobes. Data is on bit 2 and select stays 1 for both. The first strobe has clock (bit 3) low, giving 0x41|d<<2. The second has clock high, giving 0x49|d<<2.
- R6: Frame order is fixed, 21 bits. The header comes first as 1, then 0, then 0. The five location bits follow, least significant first. The thirteen program-word bits come last, least significant first.
- R7: Before each strobe of the preamble and the frame, the control byte holds its value for STROBE cycles. The strobe bit is then high for exactly one cycle. Successive strobes are therefore STROBE+1 cycles apart.
- R8: The tail wait runs from the last frame strobe. TAIL+1 cycles after that strobe, `disp_off_o` falls and `ctrl_o` becomes the saved byte OR 0x40, both in the same cycle.
- R9: FINAL cycles after the restore, `ctrl_o` becomes 0x40 OR the low four location bits. In that same cycle `done_o` pulses for one cycle and `busy_o` falls. `ctrl_o` then holds until the next request is taken.
- R10: Each interval in cycles is round(CLK_HZ × microseconds / 1e6), with a minimum of 1. The first strobe comes SETTLE+STROBE cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_loc_i | input | LOC_W | Location address of the request |
| req_word_i | input | WORD_W | Program word of the request |
| req_saved_i | input | 8 | Control byte to restore after the frame |
| ctrl_o | output | 8 | Control byte: select, data, clock, strobe |
| disp_off_o | output | 1 | Display-disable flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The checker watches the handshake on every cycle: no acceptance while busy, busy after acceptance, and `done_o` only on the falling edge of busy. On every cycle it also checks that each frame strobe lasts one cycle with the control bits held for the full strobe wait before it, that display-disable is confined to busy, and that the control byte is frozen while idle. Only the bench scenarios can show the frame contents and order, the exact gaps set by each interval, the restore value, the final location byte, and that a request made while busy leaves the frame untouched.

// File: rtl/clkgen_loader_pkg.sv
package clkgen_loader_pkg;

  // control byte bit positions (decoded by the external chip)
  localparam int unsigned CB_SEL = 0;
  localparam int unsigned CB_DAT = 2;
  localparam int unsigned CB_CLK = 3;
  localparam int unsigned CB_STB = 6;

  // fixed header, sent first, LSB first: 1, 0, 0
  localparam int unsigned HDR_W = 3;
  localparam logic [HDR_W-1:0] HDR_BITS = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PRE_WAIT,
    ST_PRE_STB,
    ST_BIT_WAIT,
    ST_BIT_STB,
    ST_TAIL,
    ST_FINAL
  } ldr_state_e;

  function automatic int unsigned cycles_for(input longint unsigned hz,
                                             input longint unsigned us);
    longint unsigned t;
    t = (hz * us + 64'd500000) / 64'd1000000;
    if (t == 0) t = 1;
    return 32'(t);
  endfunction

endpackage

// File: rtl/clkgen_loader_timer.sv
module clkgen_loader_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // a wait loaded with N is reported finished in its N-th cycle
  assign done_o = (cnt_q <= CW'(1));
endmodule

// File: rtl/clkgen_loader_frame.sv
module clkgen_loader_frame #(
  parameter int FW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  input  logic          shift_i,
  output logic          cur_bit_o,
  output logic          nxt_bit_o,
  output logic          last_o
);
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= frame_i;
      left_q <= LW'(FW);
    end else if (shift_i) begin
      sh_q   <= {1'b0, sh_q[FW-1:1]};
      left_q <= left_q - LW'(1);
    end
  end

  assign cur_bit_o = sh_q[0];
  assign nxt_bit_o = sh_q[1];
  assign last_o    = (left_q == LW'(1));
endmodule

// File: rtl/clkgen_loader.sv
module clkgen_loader
  import clkgen_loader_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_US = 15000,
  parameter int unsigned STROBE_US = 26,
  parameter int unsigned TAIL_US   = 1000,
  parameter int unsigned FINAL_US  = 50000,
  parameter int          LOC_W     = 5,
  parameter int          WORD_W    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LOC_W-1:0]  req_loc_i,
  input  logic [WORD_W-1:0] req_word_i,
  input  logic [7:0]        req_saved_i,
  output logic [7:0]        ctrl_o,
  output logic              disp_off_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned SETTLE_CYC = cycles_for(CLK_HZ, SETTLE_US);
  localparam int unsigned STROBE_CYC = cycles_for(CLK_HZ, STROBE_US);
  localparam int unsigned TAIL_CYC   = cycles_for(CLK_HZ, TAIL_US);
  localparam int unsigned FINAL_CYC  = cycles_for(CLK_HZ, FINAL_US);
  localparam int unsigned MAX_AB     = (SETTLE_CYC > FINAL_CYC) ? SETTLE_CYC : FINAL_CYC;
  localparam int unsigned MAX_CD     = (STROBE_CYC > TAIL_CYC) ? STROBE_CYC : TAIL_CYC;
  localparam int unsigned MAX_CYC    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int          CW         = $clog2(MAX_CYC + 1);
  localparam int          FW         = HDR_W + LOC_W + WORD_W;

  ldr_state_e    state_q, state_d;
  logic [7:0]    ctrl_q, ctrl_d;
  logic [7:0]    saved_q;
  logic [3:0]    loc_lo_q;
  logic          disp_q, disp_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          pre_q, pre_d;
  logic          ph_q, ph_d;
  logic          take;

  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_done;
  logic          f_shift;
  logic          f_cur, f_nxt, f_last;

  assign req_ready_o = (state_q == ST_IDLE);
  assign take        = req_valid_i && req_ready_o;

  clkgen_loader_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(t_load),
    .val_i (t_val),
    .done_o(t_done)
  );

  clkgen_loader_frame #(.FW(FW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (take),
    .frame_i  ({req_word_i, req_loc_i, HDR_BITS}),
    .shift_i  (f_shift),
    .cur_bit_o(f_cur),
    .nxt_bit_o(f_nxt),
    .last_o   (f_last)
  );

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    disp_d  = disp_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    pre_d   = pre_q;
    ph_d    = ph_q;
    t_load  = 1'b0;
    t_val   = CW'(STROBE_CYC);
    f_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          ctrl_d  = '0;
          busy_d  = 1'b1;
          t_load  = 1'b1;
          t_val   = CW'(SETTLE_CYC);
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (t_done) begin
          disp_d  = 1'b1;
          ctrl_d  = '0;
          pre_d   = 1'b0;
          t_load  = 1'b1;
          state_d = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (t_done) begin
          ctrl_d[CB_STB] = 1'b1;
          state_d        = ST_PRE_STB;
        end
      end
      ST_PRE_STB: begin
        ctrl_d[CB_STB] = 1'b0;
        t_load         = 1'b1;
        if (!pre_q) begin
          ctrl_d[CB_SEL] = 1'b1;
          pre_d          = 1'b1;
          state_d        = ST_PRE_WAIT;
        end else begin
          ctrl_d[CB_DAT] = f_cur;
          ctrl_d[CB_CLK] = 1'b0;
          ph_d           = 1'b0;
          state_d        = ST_BIT_WAIT;
        end
      end
      ST_BIT_WAIT: begin
        if (t_done) begin
          ctrl_d[CB_STB] = 1'b1;
          state_d        = ST_BIT_STB;
        end
      end
      ST_BIT_STB: begin
        ctrl_d[CB_STB] = 1'b0;
        t_load         = 1'b1;
        if (!ph_q) begin
          ctrl_d[CB_CLK] = 1'b1;
          ph_d           = 1'b1;
          state_d        = ST_BIT_WAIT;
        end else if (f_last) begin
          t_val   = CW'(TAIL_CYC);
          state_d = ST_TAIL;
        end else begin
          f_shift        = 1'b1;
          ctrl_d[CB_DAT] = f_nxt;
          ctrl_d[CB_CLK] = 1'b0;
          ph_d           = 1'b0;
          state_d        = ST_BIT_WAIT;
        end
      end
      ST_TAIL: begin
        if (t_done) begin
          disp_d         = 1'b0;
          ctrl_d         = saved_q;
          ctrl_d[CB_STB] = 1'b1;
          t_load         = 1'b1;
          t_val          = CW'(FINAL_CYC);
          state_d        = ST_FINAL;
        end
      end
      ST_FINAL: begin
        if (t_done) begin
          ctrl_d         = {4'b0000, loc_lo_q};
          ctrl_d[CB_STB] = 1'b1;
          done_d         = 1'b1;
          busy_d         = 1'b0;
          state_d        = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ctrl_q   <= '0;
      saved_q  <= '0;
      loc_lo_q <= '0;
      disp_q   <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pre_q    <= 1'b0;
      ph_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      disp_q  <= disp_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      pre_q   <= pre_d;
      ph_q    <= ph_d;
      if (take) begin
        saved_q  <= req_saved_i;
        loc_lo_q <= req_loc_i[3:0];
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign disp_off_o = disp_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
endmodule

// File: rtl/clkgen_loader_chk.sv
module clkgen_loader_chk #(
  parameter int STROBE_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [7:0] ctrl_o,
  input logic       disp_off_o,
  input logic       busy_o,
  input logic       done_o
);
  logic [5:0] prev_low_q;
  int         stable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_low_q <= '0;
      stable_q   <= 0;
    end else begin
      prev_low_q <= ctrl_o[5:0];
      if (ctrl_o[5:0] != prev_low_q) stable_q <= 0;
      else if (stable_q < 1_000_000) stable_q <= stable_q + 1;
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> busy_o);

  assert_no_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !req_ready_o);

  assert_done_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_strobe_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_o[6]) && disp_off_o) |=> !ctrl_o[6]);

  assert_strobe_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_o[6]) && disp_off_o) |-> (stable_q >= STROBE_CYC - 1));

  assert_disp_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off_o |-> busy_o);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(ctrl_o));

  assert_sel_with_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_o && ctrl_o[3]) |-> ctrl_o[0]);
endmodule

bind clkgen_loader clkgen_loader_chk #(.STROBE_CYC(int'(STROBE_CYC))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .ctrl_o     (ctrl_o),
  .disp_off_o (disp_off_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/clkgen_loader_tb.sv
module clkgen_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 20, W = 3, T = 10, F = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [4:0]  req_loc_i = '0;
  logic [12:0] req_word_i = '0;
  logic [7:0]  req_saved_i = '0;
  logic [7:0]  ctrl_o;
  logic        disp_off_o, busy_o, done_o;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  clkgen_loader #(
    .CLK_HZ(1_000_000), .SETTLE_US(S), .STROBE_US(W), .TAIL_US(T), .FINAL_US(F),
    .LOC_W(5), .WORD_W(13)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_loc_i(req_loc_i), .req_word_i(req_word_i), .req_saved_i(req_saved_i),
    .ctrl_o(ctrl_o), .disp_off_o(disp_off_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // strobe-event monitor
  logic [7:0] ev_val [64];
  logic       ev_disp[64];
  int         ev_cyc [64];
  int         ev_n = 0, acc_cyc = 0, done_cyc = 0, done_cnt = 0;
  logic       prev_stb = 1'b0, prev_busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ctrl_o[6] && !prev_stb && ev_n < 64) begin
        ev_val[ev_n]  = ctrl_o;
        ev_disp[ev_n] = disp_off_o;
        ev_cyc[ev_n]  = cyc;
        ev_n++;
      end
      if (busy_o && !prev_busy) acc_cyc = cyc;
      if (done_o) begin
        done_cyc = cyc;
        done_cnt++;
      end
    end
    prev_stb  = ctrl_o[6];
    prev_busy = busy_o;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] loc, input logic [12:0] word, input logic [7:0] saved);
    @(negedge clk);
    ev_n = 0;
    req_valid_i = 1'b1; req_loc_i = loc; req_word_i = word; req_saved_i = saved;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R3", "ctrl after accept", ctrl_o, 8'h00);
    chk("R3", "disp_off after accept", disp_off_o, 0);
    chk("R2", "busy after accept", busy_o, 1);
    chk("R2", "ready while busy", req_ready_o, 0);
  endtask

  task automatic wait_done();
    int start = done_cnt;
    int t = 0;
    while (done_cnt == start && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk("R9", "done seen", (done_cnt == start) ? 0 : 1, 1);
  endtask

  task automatic check_frame(input logic [4:0] loc, input logic [12:0] word,
                             input logic [7:0] saved, input int dn0);
    logic [20:0] fb;
    logic [7:0]  e;
    fb = {word, loc, 3'b001};
    chk("R6", "strobe event count", ev_n, 45);
    if (ev_n == 45) begin
      chk("R4", "preamble strobe 0", ev_val[0], 8'h40);
      chk("R4", "preamble strobe 1", ev_val[1], 8'h41);
      for (int i = 0; i < 21; i++) begin
        e = 8'h41 | (8'(fb[i]) << 2);
        chk("R5 R6", $sformatf("bit %0d clock low", i), ev_val[2+2*i], e);
        chk("R5 R6", $sformatf("bit %0d clock high", i), ev_val[3+2*i], e | 8'h08);
      end
      for (int i = 0; i < 44; i++) chk("R3", $sformatf("disp_off at strobe %0d", i), ev_disp[i], 1);
      chk("R8", "restore value", ev_val[44], saved | 8'h40);
      chk("R8", "disp_off released at restore", ev_disp[44], 0);
      chk("R10", "accept to first strobe", ev_cyc[0] - acc_cyc, S + W);
      for (int i = 1; i < 44; i++) chk("R7", $sformatf("strobe gap %0d", i), ev_cyc[i] - ev_cyc[i-1], W + 1);
      chk("R8", "tail gap", ev_cyc[44] - ev_cyc[43], T + 1);
      chk("R10", "final gap", done_cyc - ev_cyc[44], F);
    end
    chk("R9", "final ctrl", ctrl_o, 8'h40 | {4'h0, loc[3:0]});
    chk("R9", "busy after done", busy_o, 0);
    chk("R9", "ready after done", req_ready_o, 1);
    chk("R9", "single done pulse", done_cnt - dn0, 1);
  endtask

  task automatic t_reset();
    chk("R1", "ctrl in reset", ctrl_o, 0);
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "disp_off in reset", disp_off_o, 0);
    chk("R1", "done in reset", done_o, 0);
    chk("R1", "ready in reset", req_ready_o, 1);
  endtask

  task automatic t_program(input logic [4:0] loc, input logic [12:0] word, input logic [7:0] saved);
    int dn0 = done_cnt;
    send(loc, word, saved);
    wait_done();
    @(negedge clk);
    check_frame(loc, word, saved, dn0);
  endtask

  task automatic t_busy_ignore();
    int dn0 = done_cnt;
    send(5'b01001, 13'h0F0F, 8'h12);
    repeat (5) @(negedge clk);
    req_valid_i = 1'b1; req_loc_i = 5'b10110; req_word_i = 13'h1234; req_saved_i = 8'hAA;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2", "ready low while busy", req_ready_o, 0);
    end
    req_valid_i = 1'b0;
    wait_done();
    @(negedge clk);
    check_frame(5'b01001, 13'h0F0F, 8'h12, dn0);
  endtask

  task automatic t_idle_hold();
    logic [7:0] v = ctrl_o;
    repeat (20) @(negedge clk);
    chk("R9", "ctrl holds while idle", ctrl_o, v);
    chk("R9", "busy stays low", busy_o, 0);
  endtask

  task automatic t_mid_reset();
    send(5'h1F, 13'h1FFF, 8'h00);
    repeat (S + 10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program(5'b10110, 13'h1A5C, 8'h23);
    t_idle_hold();
    t_program(5'h1F, 13'h1FFF, 8'h00);
    t_program(5'h00, 13'h0000, 8'hFF);
    t_busy_ignore();
    t_mid_reset();
    t_program(5'b00101, 13'h0AAA, 8'h5A);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule